// File: doc/BRIEF.md
# Eight-Channel Switch Command Merge and Fault Guard

This block drives the gate enables of eight low-side switches. Each channel takes a software on/off bit from a configuration byte and may also take a shared external input pin. A per-channel routing bit decides whether the pin takes part. When it does, a per-channel operator bit merges the pin with the software bit by OR or by AND. The pin is synchronised through two flops before it is used. An open pin is expected to be pulled low at the pad.

Every channel runs its own state machine. The machine reacts to two digital indicators: one for overload and one for over-temperature. Overload can be set to keep the channel conducting (the current limit is analog and lies outside this block) and raise a flag after a programmable delay. It can also be set to turn the channel off after a second programmable delay. Over-temperature turns the channel off at once. The channel then either restarts when the indicator drops or stays off until its flag is cleared. A rising edge of the synchronised pin clears the latched flags of all channels. Both delays count ticks from a shared prescaler.

Channel states: `CH_OFF` (gate off, no command), `CH_ON` (conducting), `CH_OVL_WAIT` (conducting, overload delay counting), `CH_OVL_LIMIT` (conducting in limit, flag set), `CH_OVL_SHUT` (off after overload, latched), `CH_HOT_AUTO` (off, waiting for the temperature indicator to drop), `CH_HOT_LATCH` (off, waiting for a flag clear). Transitions: OFF→ON when the command is high. ON/OVL_WAIT/OVL_LIMIT→OFF when the command is low. Any of those three→HOT_AUTO or HOT_LATCH on the temperature indicator; this has priority. ON→OVL_WAIT on the overload indicator. OVL_WAIT/OVL_LIMIT→ON when the overload indicator drops. OVL_WAIT→OVL_LIMIT (mode 0) or OVL_SHUT (mode 1) when the delay expires. HOT_AUTO→OFF when the temperature indicator drops. OVL_SHUT/HOT_LATCH→OFF on a clear event.

Top module: `chan_guard_bank`

## Requirements
- R1: A channel whose routing bit (`map_cfg[i]`) is 0 follows only `ctl_cfg[i]`. The pin level has no effect on it.
- R2: A routed channel with `oper_cfg[i]`=0 is commanded on when `ctl_cfg[i]` OR the pin is 1.
- R3: A routed channel with `oper_cfg[i]`=1 is commanded on only when `ctl_cfg[i]` AND the pin are 1.
- R4: A gate follows a configuration change one clock later. It follows a pin change three clocks later.
- R5: With `ovl_mode[i]`=0, a channel under continuous overload keeps its gate on and sets `ovl_flag[i]` after `lim_dly` prescaler ticks.
- R6: With `ovl_mode[i]`=1, a channel under continuous overload turns off and sets `ovl_flag[i]` after `sd_dly` ticks. It stays off while commanded on until a clear event.
- R7: An overload indication that ends before its delay expires sets no flag, and the delay count starts again from zero.
- R8: The temperature indicator turns a conducting gate off on the next clock and sets `ovt_flag[i]`. With `ovt_mode[i]`=0 the channel turns back on once the indicator drops. The flag stays set.
- R9: With `ovt_mode[i]`=1, a channel stopped by temperature stays off, even while commanded, until a clear event.
- R10: A low-to-high transition of the synchronised pin clears `ovl_flag` and `ovt_flag` of every channel. Latched channels then resume if commanded.
- R11: During reset all gates are off and all flags are clear, whatever the configuration inputs.
- R12: Indicators have no effect on a channel that is not commanded on: its gate stays off and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Shared external control pin, asynchronous |
| map_cfg | input | 8 | Per-channel pin routing enable |
| oper_cfg | input | 8 | Per-channel merge operator, 0 = OR, 1 = AND |
| ctl_cfg | input | 8 | Per-channel software on/off command |
| ovl_mode | input | 8 | Per-channel overload reaction, 0 = limit and flag, 1 = shut down |
| ovt_mode | input | 8 | Per-channel temperature reaction, 0 = auto restart, 1 = latched off |
| ovl_ind | input | 8 | Per-channel overload indicator |
| ovt_ind | input | 8 | Per-channel over-temperature indicator |
| lim_dly | input | 8 | Flag delay in ticks for overload mode 0 |
| sd_dly | input | 8 | Shutdown delay in ticks for overload mode 1 |
| gate_en | output | 8 | Per-channel gate enable |
| ovl_flag | output | 8 | Latched overload flags |
| ovt_flag | output | 8 | Latched over-temperature flags |

## Verification
A channel stuck in the wrong state shows up on `gate_en` within one clock of the next command or indicator change. A latched state that fails to release shows up as a gate held low four clocks after a pin rise. A delay counter that is not reset, or that runs too fast, shows up as `ovl_flag` rising before the earliest tick count allows. The bench therefore samples each flag once just before the earliest legal expiry and once just after the latest. A missed clear shows up as a flag still high four clocks after the pin edge.

// File: rtl/chg_pkg.sv
package chg_pkg;
    typedef enum logic [2:0] {
        CH_OFF,
        CH_ON,
        CH_OVL_WAIT,
        CH_OVL_LIMIT,
        CH_OVL_SHUT,
        CH_HOT_AUTO,
        CH_HOT_LATCH
    } ch_state_e;
endpackage

// File: rtl/chg_pin_sync.sv
module chg_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic pin_lvl,
    output logic pin_rise
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= pin_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign pin_lvl  = s2_q;
    assign pin_rise = s2_q & ~s3_q;

    // R10: a clear event lasts exactly one clock
    assert_rise_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rise |=> !pin_rise);
endmodule

// File: rtl/chg_tick_gen.sv
module chg_tick_gen #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;

    logic [PW-1:0] div_q;
    logic          tick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            tick_q <= 1'b0;
        end else if (div_q == PW'(TICK_DIV - 1)) begin
            div_q  <= '0;
            tick_q <= 1'b1;
        end else begin
            div_q  <= div_q + 1'b1;
            tick_q <= 1'b0;
        end
    end

    assign tick = tick_q;

    // R5: ticks are isolated pulses, so delays count whole prescaler periods
    assert_tick_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/chg_channel.sv
module chg_channel
    import chg_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr_ev,
    input  logic             cmd,
    input  logic             ovl_ind,
    input  logic             ovt_ind,
    input  logic             ovl_mode,
    input  logic             ovt_mode,
    input  logic [DLY_W-1:0] lim_dly,
    input  logic [DLY_W-1:0] sd_dly,
    output logic             gate_en,
    output logic             ovl_flag,
    output logic             ovt_flag
);
    ch_state_e        st_q, st_d;
    logic [DLY_W-1:0] cnt_q;
    logic [DLY_W:0]   cnt_inc;
    logic [DLY_W:0]   dly_sel;
    logic             expire;
    ch_state_e        hot_st;
    logic             ovl_set, ovt_set;
    logic             ovl_q, ovt_q;

    assign dly_sel = {1'b0, (ovl_mode ? sd_dly : lim_dly)};
    assign cnt_inc = {1'b0, cnt_q} + {{DLY_W{1'b0}}, 1'b1};
    assign expire  = tick && (cnt_inc >= dly_sel);
    assign hot_st  = ovt_mode ? CH_HOT_LATCH : CH_HOT_AUTO;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_OFF:       if (cmd) st_d = CH_ON;
            CH_ON: begin
                if (ovt_ind)      st_d = hot_st;
                else if (!cmd)    st_d = CH_OFF;
                else if (ovl_ind) st_d = CH_OVL_WAIT;
            end
            CH_OVL_WAIT: begin
                if (ovt_ind)       st_d = hot_st;
                else if (!cmd)     st_d = CH_OFF;
                else if (!ovl_ind) st_d = CH_ON;
                else if (expire)   st_d = ovl_mode ? CH_OVL_SHUT : CH_OVL_LIMIT;
            end
            CH_OVL_LIMIT: begin
                if (ovt_ind)       st_d = hot_st;
                else if (!cmd)     st_d = CH_OFF;
                else if (!ovl_ind) st_d = CH_ON;
            end
            CH_OVL_SHUT:  if (clr_ev)   st_d = CH_OFF;
            CH_HOT_AUTO:  if (!ovt_ind) st_d = CH_OFF;
            CH_HOT_LATCH: if (clr_ev)   st_d = CH_OFF;
            default:      st_d = CH_OFF;
        endcase
    end

    assign ovl_set = (st_q == CH_OVL_WAIT) &&
                     (st_d == CH_OVL_SHUT || st_d == CH_OVL_LIMIT);
    assign ovt_set = (st_q == CH_ON || st_q == CH_OVL_WAIT || st_q == CH_OVL_LIMIT) &&
                     (st_d == CH_HOT_AUTO || st_d == CH_HOT_LATCH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CH_OFF;
            cnt_q <= '0;
            ovl_q <= 1'b0;
            ovt_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q != CH_OVL_WAIT || st_d != CH_OVL_WAIT) cnt_q <= '0;
            else if (tick)                                  cnt_q <= cnt_inc[DLY_W-1:0];
            if (ovl_set)     ovl_q <= 1'b1;
            else if (clr_ev) ovl_q <= 1'b0;
            if (ovt_set)     ovt_q <= 1'b1;
            else if (clr_ev) ovt_q <= 1'b0;
        end
    end

    always_comb begin
        gate_en  = (st_q == CH_ON) || (st_q == CH_OVL_WAIT) || (st_q == CH_OVL_LIMIT);
        ovl_flag = ovl_q;
        ovt_flag = ovt_q;
    end

    // R1: without a command the gate is off on the next clock
    assert_nocmd_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd |=> !gate_en);
    // R8: temperature trip turns a conducting gate off and flags it
    assert_hot_trip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovt_ind && gate_en) |=> (!gate_en && ovt_flag));
    // R6: a latched overload shutdown holds the gate off until cleared
    assert_shut_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_OVL_SHUT && !clr_ev) |=> !gate_en);
    // R10: a clear event with no active indicator leaves both flags low
    assert_clear_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ev && !ovl_ind && !ovt_ind) |=> (!ovl_flag && !ovt_flag));
    // R12: an idle channel cannot raise an overload flag on its own
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_OFF && !ovl_flag) |=> !ovl_flag);
endmodule

// File: rtl/chan_guard_bank.sv
module chan_guard_bank #(
    parameter int NCH      = 8,
    parameter int DLY_W    = 8,
    parameter int TICK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic [NCH-1:0]   map_cfg,
    input  logic [NCH-1:0]   oper_cfg,
    input  logic [NCH-1:0]   ctl_cfg,
    input  logic [NCH-1:0]   ovl_mode,
    input  logic [NCH-1:0]   ovt_mode,
    input  logic [NCH-1:0]   ovl_ind,
    input  logic [NCH-1:0]   ovt_ind,
    input  logic [DLY_W-1:0] lim_dly,
    input  logic [DLY_W-1:0] sd_dly,
    output logic [NCH-1:0]   gate_en,
    output logic [NCH-1:0]   ovl_flag,
    output logic [NCH-1:0]   ovt_flag
);
    logic           pin_lvl, pin_rise, tick;
    logic [NCH-1:0] cmd;

    chg_pin_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .pin_lvl  (pin_lvl),
        .pin_rise (pin_rise)
    );

    chg_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        always_comb begin
            if (!map_cfg[i])      cmd[i] = ctl_cfg[i];
            else if (oper_cfg[i]) cmd[i] = ctl_cfg[i] & pin_lvl;
            else                  cmd[i] = ctl_cfg[i] | pin_lvl;
        end

        chg_channel #(.DLY_W(DLY_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .clr_ev   (pin_rise),
            .cmd      (cmd[i]),
            .ovl_ind  (ovl_ind[i]),
            .ovt_ind  (ovt_ind[i]),
            .ovl_mode (ovl_mode[i]),
            .ovt_mode (ovt_mode[i]),
            .lim_dly  (lim_dly),
            .sd_dly   (sd_dly),
            .gate_en  (gate_en[i]),
            .ovl_flag (ovl_flag[i]),
            .ovt_flag (ovt_flag[i])
        );
    end

    // R11: reset drives every gate and flag low
    always_comb begin
        if (!rst_n) begin
            assert_reset_quiet_R11: assert (gate_en == '0 && ovl_flag == '0 && ovt_flag == '0);
        end
    end
endmodule

// File: tb/sim_chan_guard_bank.sv
module sim_chan_guard_bank;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       pin_in;
    logic [7:0] map_cfg, oper_cfg, ctl_cfg, ovl_mode, ovt_mode, ovl_ind, ovt_ind;
    logic [7:0] lim_dly, sd_dly;
    logic [7:0] gate_en, ovl_flag, ovt_flag;
    int         checks = 0;
    int         errors = 0;
    bit         done   = 1'b0;

    always #2 clk = ~clk;

    chan_guard_bank u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .map_cfg(map_cfg), .oper_cfg(oper_cfg), .ctl_cfg(ctl_cfg),
        .ovl_mode(ovl_mode), .ovt_mode(ovt_mode),
        .ovl_ind(ovl_ind), .ovt_ind(ovt_ind),
        .lim_dly(lim_dly), .sd_dly(sd_dly),
        .gate_en(gate_en), .ovl_flag(ovl_flag), .ovt_flag(ovt_flag)
    );

    // {map, oper, ctl, pin, expected gate}
    localparam logic [39:0] VEC [8] = '{
        {8'h00, 8'h00, 8'hA5, 8'h01, 8'hA5},   // R1
        {8'hFF, 8'h00, 8'h0F, 8'h00, 8'h0F},   // R2
        {8'hFF, 8'h00, 8'h0F, 8'h01, 8'hFF},   // R2
        {8'hFF, 8'hFF, 8'h3C, 8'h01, 8'h3C},   // R3
        {8'hFF, 8'hFF, 8'h3C, 8'h00, 8'h00},   // R3
        {8'hF0, 8'hCC, 8'h5A, 8'h01, 8'h7A},   // R1 R2 R3 mixed
        {8'hF0, 8'hCC, 8'h5A, 8'h00, 8'h1A},   // R1 R2 R3 mixed
        {8'h08, 8'h00, 8'h00, 8'h01, 8'h08}    // R2 single routed channel
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pin_in = 1'b0;
        map_cfg = 8'h00; oper_cfg = 8'h00; ctl_cfg = 8'hFF;
        ovl_mode = 8'h00; ovt_mode = 8'h00; ovl_ind = 8'h00; ovt_ind = 8'h00;
        lim_dly = 8'd5; sd_dly = 8'd3;
        step(3);
        chk("R11 gate", gate_en, 8'h00);
        chk("R11 flags", ovl_flag | ovt_flag, 8'h00);
        rst_n = 1'b1;
        step(1);
        chk("R4 after reset", gate_en, 8'hFF);

        for (int v = 0; v < 8; v++) begin
            map_cfg  = VEC[v][39:32];
            oper_cfg = VEC[v][31:24];
            ctl_cfg  = VEC[v][23:16];
            pin_in   = VEC[v][8];
            step(4);
            chk("R1/R2/R3 vector", gate_en, VEC[v][7:0]);
        end

        map_cfg = 8'h00; oper_cfg = 8'h00; ctl_cfg = 8'h01; pin_in = 1'b0;
        step(4);
        // R4: configuration latency
        ctl_cfg = 8'h03;
        #1 chk("R4 before edge", gate_en, 8'h01);
        step(1);
        chk("R4 one clock", gate_en, 8'h03);
        ctl_cfg = 8'h01;
        step(1);
        // R4: pin latency on a routed OR channel
        map_cfg = 8'h02; pin_in = 1'b1;
        step(2);
        chk("R4 pin two clocks", gate_en, 8'h01);
        step(1);
        chk("R4 pin three clocks", gate_en, 8'h03);
        pin_in = 1'b0; map_cfg = 8'h00;
        step(4);

        // R7: short overload, then restart of the count
        ovl_ind = 8'h01;
        step(12);
        ovl_ind = 8'h00;
        step(1);
        ovl_ind = 8'h01;
        step(17);
        chk("R7 no flag after restart", ovl_flag, 8'h00);
        // R5: keeps running, flag after 5 ticks
        step(4);
        chk("R5 flag set", ovl_flag, 8'h01);
        chk("R5 still conducting", gate_en, 8'h01);
        ovl_ind = 8'h00;
        step(2);
        pin_in = 1'b1; step(4);
        chk("R10 overload flag cleared", ovl_flag, 8'h00);
        pin_in = 1'b0; step(3);

        // R6: shutdown after 3 ticks
        ovl_mode = 8'h01;
        ovl_ind  = 8'h01;
        step(9);
        chk("R6 on before delay", gate_en, 8'h01);
        step(4);
        chk("R6 off after delay", gate_en, 8'h00);
        chk("R6 flag", ovl_flag, 8'h01);
        ovl_ind = 8'h00;
        step(5);
        chk("R6 held off while commanded", gate_en, 8'h00);
        pin_in = 1'b1; step(4);
        chk("R10 resume after clear", gate_en, 8'h01);
        chk("R10 flag low", ovl_flag, 8'h00);
        pin_in = 1'b0; step(3);
        ovl_mode = 8'h00;

        // R8: temperature, auto restart
        ovt_ind = 8'h01;
        step(1);
        chk("R8 off next clock", gate_en, 8'h00);
        chk("R8 flag", ovt_flag, 8'h01);
        ovt_ind = 8'h00;
        step(2);
        chk("R8 restart", gate_en, 8'h01);
        chk("R8 flag kept", ovt_flag, 8'h01);
        pin_in = 1'b1; step(4);
        chk("R10 temp flag cleared", ovt_flag, 8'h00);
        pin_in = 1'b0; step(3);

        // R9: temperature, latched
        ovt_mode = 8'h01;
        ovt_ind  = 8'h01;
        step(1);
        ovt_ind = 8'h00;
        step(5);
        chk("R9 held off", gate_en, 8'h00);
        pin_in = 1'b1; step(4);
        chk("R9 resume after clear", gate_en, 8'h01);
        chk("R9 flag cleared", ovt_flag, 8'h00);
        pin_in = 1'b0; step(3);
        ovt_mode = 8'h00;

        // R12: indicators on an idle channel
        ctl_cfg = 8'h00;
        step(2);
        ovl_ind = 8'h01; ovt_ind = 8'h01;
        step(30);
        chk("R12 gate off", gate_en, 8'h00);
        chk("R12 no flags", ovl_flag | ovt_flag, 8'h00);
        ovl_ind = 8'h00; ovt_ind = 8'h00;
        step(2);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule